// File: doc/BRIEF.md
# Edge-Selectable Timer Capture Unit

The unit watches one asynchronous capture pin and, when the selected kind of edge event occurs, stores the current value of a free-running timer in a four-entry queue. A six-bit mode word selects the behaviour. Bit 4 enables capture. Bit 5 chooses a 32-bit or 16-bit stored value. Bits 3:0 pick the event: any edge, rising only, falling only, both edges, every fourth rising edge, or every sixteenth rising edge. Software or a neighbouring block drains the queue with a one-cycle pop strobe. The oldest stored value is always visible on the output word.

Two status flags go with the queue. One shows that it holds data. The other is a sticky overrun flag, set when a capture is lost because the queue is full. A five-state fill machine tracks the queue and both flags:

- **EMPTY**: no data and no overrun. *Store* moves it to HOLD.
- **HOLD**: partly filled. *Fill* moves it to FULL and *Drain* moves it back to EMPTY.
- **FULL**: four entries, no loss yet. A dropped capture (*Lose*) moves it to LOST_FULL. A pop moves it to HOLD.
- **LOST_FULL**: full with the overrun flag set. A pop moves it to LOST_DRAIN.
- **LOST_DRAIN**: partly filled with the overrun flag still set. *Refill* moves it to LOST_FULL, and *Clear* moves it to EMPTY when the last entry leaves.

Top module: `edge_capture_unit`

## Requirements
- R1: While reset is asserted and right after it, `fifo_nonempty` is 0, `overrun` is 0 and `cap_word` is 0.
- R2: `cap_in` passes through two synchronizing flops and an edge detector. A level change first sampled at rising clock edge k stores the `timer_val` sampled at edge k+2.
- R3: When `mode[4]` is 0, no capture happens, whatever the other mode bits are.
- R4: With `mode[4]`=1, sub-mode `mode[3:0]`=0000 and sub-mode 0011 both capture on every rising and every falling edge.
- R5: Sub-mode 0001 captures on rising edges only.
- R6: Sub-mode 0010 captures on falling edges only.
- R7: Sub-mode 0100 captures on every 4th rising edge and sub-mode 0101 on every 16th rising edge, counted from the last mode change.
- R8: A clock cycle in which `mode` differs from its value in the previous cycle clears the rising-edge prescale count. A rising edge seen in that cycle is not counted.
- R9: Sub-modes 0110 through 1111 never capture.
- R10: With `mode[5]`=0 the stored word is `timer_val[15:0]` zero-extended to 32 bits. With `mode[5]`=1 all 32 bits are stored. The width in force in the cycle of the store is the one that applies.
- R11: The queue holds 4 entries. `cap_word` shows the oldest entry, or 0 when the queue is empty. A `rd_pop` removes the oldest entry, and a `rd_pop` on an empty queue has no effect.
- R12: A capture that meets a full queue with no pop in the same cycle is dropped and sets `overrun`. If a pop occurs in the same cycle, the capture is stored.
- R13: `overrun` stays set until the queue becomes empty, and is cleared in that same cycle.
- R14: `fifo_nonempty` is 1 exactly when the queue holds at least one entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cap_in | input | 1 | Asynchronous capture pin |
| mode | input | 6 | [5] wide store, [4] capture enable, [3:0] event sub-mode |
| timer_val | input | 32 | Free-running timer value |
| rd_pop | input | 1 | Pops the oldest queue entry |
| cap_word | output | 32 | Oldest stored value, 0 when empty |
| fifo_nonempty | output | 1 | Queue holds data |
| overrun | output | 1 | Sticky flag for a lost capture |

## Verification
A capture store and a pop can land in the same cycle, and this pairing decides the fill state. At a full queue it turns a would-be loss into an accepted store. When the last entry leaves, it keeps `overrun` set because the queue never reaches zero. The bench produces this coincidence deliberately by raising `rd_pop` exactly two cycles after toggling `cap_in` at a full queue. It also gets it many times by chance in a long random run of toggles, pops and mode changes. A behavioural queue model judges every cycle by comparing the head word and both flags.

// File: rtl/ecu_pkg.sv
package ecu_pkg;

    localparam int MODE_W    = 6;
    localparam int WIDE_BIT  = 5;
    localparam int CAPEN_BIT = 4;

    typedef enum logic [3:0] {
        SEL_ANY    = 4'd0,
        SEL_RISE   = 4'd1,
        SEL_FALL   = 4'd2,
        SEL_BOTH   = 4'd3,
        SEL_RISE_Q = 4'd4,
        SEL_RISE_H = 4'd5
    } sel_e;

    typedef enum logic [2:0] {
        ST_EMPTY,
        ST_HOLD,
        ST_FULL,
        ST_LOST_FULL,
        ST_LOST_DRAIN
    } fill_e;

endpackage

// File: rtl/ecu_sync_edge.sv
module ecu_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic rise,
    output logic fall
);
    logic [STAGES-1:0] chain;
    logic              last;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain <= '0;
            last  <= 1'b0;
        end else begin
            chain <= {chain[STAGES-2:0], din};
            last  <= chain[STAGES-1];
        end
    end

    assign rise = chain[STAGES-1] & ~last;
    assign fall = ~chain[STAGES-1] & last;
endmodule

// File: rtl/ecu_event_sel.sv
module ecu_event_sel
    import ecu_pkg::*;
#(
    parameter int PRE_Q = 4,
    parameter int PRE_H = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [MODE_W-1:0] mode,
    input  logic              rise,
    input  logic              fall,
    output logic              fire
);
    localparam int CNT_W = $clog2(PRE_H);
    localparam logic [CNT_W-1:0] LAST_Q = CNT_W'(PRE_Q - 1);
    localparam logic [CNT_W-1:0] LAST_H = CNT_W'(PRE_H - 1);

    logic [MODE_W-1:0] mode_q;
    logic [CNT_W-1:0]  pre_cnt;
    logic              changed;
    logic              pre_sel;
    logic [CNT_W-1:0]  pre_last;

    assign changed = (mode != mode_q);

    always_comb begin
        fire     = 1'b0;
        pre_sel  = 1'b0;
        pre_last = LAST_Q;
        if (mode[CAPEN_BIT]) begin
            unique case (mode[3:0])
                SEL_ANY, SEL_BOTH: fire = rise | fall;
                SEL_RISE:          fire = rise;
                SEL_FALL:          fire = fall;
                SEL_RISE_Q: begin
                    pre_sel  = 1'b1;
                    pre_last = LAST_Q;
                    fire     = rise & ~changed & (pre_cnt == LAST_Q);
                end
                SEL_RISE_H: begin
                    pre_sel  = 1'b1;
                    pre_last = LAST_H;
                    fire     = rise & ~changed & (pre_cnt == LAST_H);
                end
                default:           fire = 1'b0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q  <= '0;
            pre_cnt <= '0;
        end else begin
            mode_q <= mode;
            if (changed) begin
                pre_cnt <= '0;
            end else if (pre_sel && rise) begin
                pre_cnt <= (pre_cnt == pre_last) ? '0 : pre_cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/ecu_fifo.sv
module ecu_fifo #(
    parameter int DW    = 32,
    parameter int DEPTH = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       push,
    input  logic                       pop,
    input  logic [DW-1:0]              din,
    output logic [DW-1:0]              head,
    output logic                       drop,
    output logic [$clog2(DEPTH+1)-1:0] cnt_nxt
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
    localparam logic [AW-1:0] LAST_IX  = AW'(DEPTH - 1);

    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic [CW-1:0] cnt;
    logic          pop_ok, push_ok;

    assign pop_ok  = pop && (cnt != '0);
    assign push_ok = push && ((cnt != FULL_CNT) || pop_ok);
    assign drop    = push && !push_ok;
    assign head    = (cnt != '0) ? mem[rp] : '0;

    always_comb begin
        cnt_nxt = cnt;
        if (push_ok && !pop_ok) cnt_nxt = cnt + 1'b1;
        if (pop_ok && !push_ok) cnt_nxt = cnt - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            cnt <= cnt_nxt;
            if (push_ok) wp <= (wp == LAST_IX) ? '0 : wp + 1'b1;
            if (pop_ok)  rp <= (rp == LAST_IX) ? '0 : rp + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (push_ok) mem[wp] <= din;
    end
endmodule

// File: rtl/ecu_status_fsm.sv
module ecu_status_fsm
    import ecu_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       drop,
    input  logic [$clog2(DEPTH+1)-1:0] cnt_nxt,
    output logic                       nonempty,
    output logic                       overrun
);
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

    fill_e state, state_nxt;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_EMPTY;
        else        state <= state_nxt;
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_EMPTY, ST_HOLD, ST_FULL: begin
                if (drop)                    state_nxt = ST_LOST_FULL;   // Lose
                else if (cnt_nxt == '0)      state_nxt = ST_EMPTY;       // Drain
                else if (cnt_nxt == FULL_CNT) state_nxt = ST_FULL;       // Fill
                else                         state_nxt = ST_HOLD;        // Store
            end
            ST_LOST_FULL, ST_LOST_DRAIN: begin
                if (drop)                    state_nxt = ST_LOST_FULL;
                else if (cnt_nxt == '0)      state_nxt = ST_EMPTY;       // Clear
                else if (cnt_nxt == FULL_CNT) state_nxt = ST_LOST_FULL;  // Refill
                else                         state_nxt = ST_LOST_DRAIN;
            end
            default:                         state_nxt = ST_EMPTY;
        endcase
    end

    always_comb begin
        nonempty = 1'b0;
        overrun  = 1'b0;
        unique case (state)
            ST_EMPTY:      ;
            ST_HOLD,
            ST_FULL:       nonempty = 1'b1;
            ST_LOST_FULL,
            ST_LOST_DRAIN: begin
                nonempty = 1'b1;
                overrun  = 1'b1;
            end
            default:       ;
        endcase
    end
endmodule

// File: rtl/edge_capture_unit.sv
module edge_capture_unit
    import ecu_pkg::*;
#(
    parameter int TW    = 32,
    parameter int NW    = 16,
    parameter int DEPTH = 4,
    parameter int SYNC  = 2,
    parameter int PRE_Q = 4,
    parameter int PRE_H = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_in,
    input  logic [MODE_W-1:0] mode,
    input  logic [TW-1:0]     timer_val,
    input  logic              rd_pop,
    output logic [TW-1:0]     cap_word,
    output logic              fifo_nonempty,
    output logic              overrun
);
    localparam int CW = $clog2(DEPTH + 1);

    logic          pin_rise, pin_fall;
    logic          evt_fire;
    logic          fifo_drop;
    logic [CW-1:0] fill_nxt;
    logic [TW-1:0] store_word;

    assign store_word = mode[WIDE_BIT] ? timer_val : TW'(timer_val[NW-1:0]);

    ecu_sync_edge #(.STAGES(SYNC)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (cap_in),
        .rise (pin_rise),
        .fall (pin_fall)
    );

    ecu_event_sel #(.PRE_Q(PRE_Q), .PRE_H(PRE_H)) u_sel (
        .clk  (clk),
        .rst_n(rst_n),
        .mode (mode),
        .rise (pin_rise),
        .fall (pin_fall),
        .fire (evt_fire)
    );

    ecu_fifo #(.DW(TW), .DEPTH(DEPTH)) u_fifo (
        .clk    (clk),
        .rst_n  (rst_n),
        .push   (evt_fire),
        .pop    (rd_pop),
        .din    (store_word),
        .head   (cap_word),
        .drop   (fifo_drop),
        .cnt_nxt(fill_nxt)
    );

    ecu_status_fsm #(.DEPTH(DEPTH)) u_stat (
        .clk     (clk),
        .rst_n   (rst_n),
        .drop    (fifo_drop),
        .cnt_nxt (fill_nxt),
        .nonempty(fifo_nonempty),
        .overrun (overrun)
    );
endmodule

// File: rtl/ecu_checker.sv
module ecu_checker #(
    parameter int TW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic [5:0]    mode,
    input logic          rd_pop,
    input logic [TW-1:0] cap_word,
    input logic          fifo_nonempty,
    input logic          overrun,
    input logic          evt_fire,
    input logic          fifo_drop
);
    assert_ovr_has_data_R13: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |-> fifo_nonempty);

    assert_ovr_sticky_R13: assert property (@(posedge clk) disable iff (!rst_n)
        overrun && !rd_pop |=> overrun);

    assert_no_capture_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !mode[4] |-> !evt_fire);

    assert_reserved_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mode[4] && mode[3:0] > 4'd5) |-> !evt_fire);

    assert_head_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_nonempty && !rd_pop |=> $stable(cap_word));

    assert_empty_stays_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !fifo_nonempty && !evt_fire |=> !fifo_nonempty);

    assert_drop_flags_R12: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_drop |=> overrun);

    assert_empty_word_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !fifo_nonempty |-> (cap_word == '0));
endmodule

bind edge_capture_unit ecu_checker #(.TW(TW)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .mode         (mode),
    .rd_pop       (rd_pop),
    .cap_word     (cap_word),
    .fifo_nonempty(fifo_nonempty),
    .overrun      (overrun),
    .evt_fire     (evt_fire),
    .fifo_drop    (fifo_drop)
);

// File: tb/test_edge_capture_unit.sv
`timescale 1ns/1ps
module test_edge_capture_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cap_in = 1'b0;
    logic [5:0]  mode = 6'h00;
    logic [31:0] timer_val = 32'h0;
    logic        rd_pop = 1'b0;
    logic [31:0] cap_word;
    logic        fifo_nonempty;
    logic        overrun;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    string phase_req = "R1";

    edge_capture_unit i_edge_capture_unit (
        .clk(clk), .rst_n(rst_n), .cap_in(cap_in), .mode(mode),
        .timer_val(timer_val), .rd_pop(rd_pop), .cap_word(cap_word),
        .fifo_nonempty(fifo_nonempty), .overrun(overrun)
    );

    always #2.5 clk = ~clk;

    // behavioural reference
    logic [31:0] q[$];
    bit s1, s2, s3, m_ovf;
    logic [5:0] m_mode;
    int pcnt;

    always @(posedge clk) begin
        if (!rst_n) begin
            q.delete(); s1 = 0; s2 = 0; s3 = 0; m_ovf = 0; m_mode = 0; pcnt = 0;
        end else begin
            bit r, f, ch, ev, popok, pushok;
            int lim;
            r  = s2 && !s3;
            f  = !s2 && s3;
            ch = (mode != m_mode);
            ev = 0;
            lim = (mode[3:0] == 4'd4) ? 4 : 16;
            if (mode[4]) begin
                case (mode[3:0])
                    4'd0, 4'd3: ev = r || f;
                    4'd1: ev = r;
                    4'd2: ev = f;
                    4'd4, 4'd5: if (!ch && r && pcnt == lim - 1) ev = 1;
                    default: ev = 0;
                endcase
            end
            if (ch) pcnt = 0;
            else if (mode[4] && (mode[3:0] == 4'd4 || mode[3:0] == 4'd5) && r)
                pcnt = (pcnt == lim - 1) ? 0 : pcnt + 1;
            popok  = rd_pop && q.size() > 0;
            pushok = ev && (q.size() < 4 || popok);
            if (popok) void'(q.pop_front());
            if (pushok) q.push_back(mode[5] ? timer_val : {16'h0, timer_val[15:0]});
            if (ev && !pushok) m_ovf = 1;
            if (q.size() == 0) m_ovf = 0;
            s3 = s2; s2 = s1; s1 = cap_in; m_mode = mode;
        end
    end

    task automatic check_outputs();
        logic [31:0] ew;
        ew = (q.size() > 0) ? q[0] : 32'h0;
        checks++;
        if (cap_word !== ew) begin
            fails++;
            $display("FAIL %s cap_word actual %h expected %h at cycle %0d", phase_req, cap_word, ew, cyc);
        end
        if (fifo_nonempty !== (q.size() > 0)) begin
            fails++;
            $display("FAIL R14 fifo_nonempty actual %b expected %b at cycle %0d", fifo_nonempty, q.size() > 0, cyc);
        end
        if (overrun !== m_ovf) begin
            fails++;
            $display("FAIL %s/R13 overrun actual %b expected %b at cycle %0d", phase_req, overrun, m_ovf, cyc);
        end
    endtask

    always @(negedge clk) begin
        cyc <= cyc + 1;
        timer_val <= {16'hC3A5 ^ 16'(cyc * 7), 16'(cyc)};
        if (rst_n) check_outputs();
    end

    task automatic toggle(int n, int gap);
        for (int i = 0; i < n; i++) begin
            cap_in = ~cap_in;
            repeat (gap) @(negedge clk);
        end
    endtask

    task automatic drain();
        for (int i = 0; i < 6; i++) begin
            rd_pop = 1'b1;
            @(negedge clk);
        end
        rd_pop = 1'b0;
        @(negedge clk);
    endtask

    task automatic finish_run();
        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired: actual running expected finished");
        finish_run();
    end

    initial begin
        logic [5:0] mlist [8];
        mlist = '{6'h10, 6'h31, 6'h12, 6'h33, 6'h14, 6'h35, 6'h18, 6'h01};
        repeat (3) @(negedge clk);
        phase_req = "R1";
        check_outputs();
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        phase_req = "R3";  mode = 6'h00; toggle(6, 3); mode = 6'h21; toggle(6, 3);
        phase_req = "R4";  mode = 6'h10; toggle(3, 3); drain();
        mode = 6'h13; toggle(3, 4); drain();
        phase_req = "R10"; mode = 6'h30; toggle(2, 3); drain();
        mode = 6'h10; toggle(1, 3); mode = 6'h30; toggle(1, 3); drain();
        phase_req = "R5";  mode = 6'h11; toggle(6, 3); drain();
        phase_req = "R6";  mode = 6'h12; toggle(6, 3); drain();
        phase_req = "R7";  mode = 6'h34; toggle(16, 3); drain();
        mode = 6'h15; toggle(34, 2); drain();
        phase_req = "R8";  mode = 6'h14; toggle(6, 3);
        mode = 6'h34; toggle(6, 3); toggle(2, 3); drain();
        phase_req = "R9";  mode = 6'h17; toggle(6, 3); mode = 6'h1F; toggle(6, 3);
        phase_req = "R12"; mode = 6'h10; toggle(5, 3);
        toggle(1, 1); @(negedge clk); rd_pop = 1'b1; @(negedge clk); rd_pop = 1'b0;
        repeat (3) @(negedge clk);
        phase_req = "R13";
        for (int i = 0; i < 5; i++) begin
            rd_pop = 1'b1; @(negedge clk); rd_pop = 1'b0; repeat (2) @(negedge clk);
        end
        phase_req = "R11";
        for (int i = 0; i < 3; i++) begin
            rd_pop = 1'b1; @(negedge clk);
        end
        rd_pop = 1'b0;
        mode = 6'h10; toggle(2, 3);
        rd_pop = 1'b1; @(negedge clk); rd_pop = 1'b0; repeat (2) @(negedge clk);
        drain();

        phase_req = "R2";
        for (int i = 0; i < 4000; i++) begin
            if (i % 150 == 0) mode = mlist[$urandom % 8];
            if ($urandom % 3 == 0) cap_in = ~cap_in;
            rd_pop = ($urandom % 6 == 0);
            @(negedge clk);
        end
        rd_pop = 1'b0;
        drain();
        finish_run();
    end
endmodule